// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This block turns the operand fields of a single-register load or store into the values the memory stage needs. These are the address to access, the width of the access, the data to write, and whether the base register is updated and with what value. One request enters on a valid strobe. All results appear registered on the next clock edge and are marked by a one-cycle output valid pulse. The shifted register offset arrives already shifted from a separate shifter.

The base value gets a prefetch correction of eight when it comes from the program counter. An offset magnitude, either a zero-extended immediate or a register value, is then added or subtracted with 32-bit wraparound. A pre/post select chooses whether the access uses the result or the corrected base. Writeback puts the effective address into the base register. Requesting writeback with the destination equal to the base is rejected: the request is flagged as illegal and no access or writeback is issued. A legal load into the program counter asks for a pipeline flush. A small side path formats returning load data, zero-extending byte loads.

Top module: `ldst_agu`

## Requirements
- R1: Each cycle with `in_valid` high produces `out_valid` high on the next cycle only, and `out_valid` is never high in a cycle that does not follow an `in_valid` cycle.
- R2: When `base_is_pc` is 1 the base value used for addressing is `base_val + 8`; otherwise it is `base_val` unchanged.
- R3: The offset magnitude is the 12-bit `off_imm` zero-extended when `off_is_reg` is 0, and `off_reg_val` when it is 1. `off_up` = 1 adds it to the corrected base and `off_up` = 0 subtracts it, modulo 2^32.
- R4: With `pre_index` = 1, `acc_addr` is the effective address; with `pre_index` = 0, it is the corrected base.
- R5: A legal request with `wb_en` = 1 gives `wb_valid` = 1, `wb_reg` = `rn` and `wb_value` = effective address; otherwise `wb_valid` is 0.
- R6: A request with `wb_en` = 1 and `rn` equal to `rd` gives `illegal` = 1 with `acc_valid`, `wb_valid` and `flush_req` all 0; any other request gives `illegal` = 0 and `acc_valid` = 1.
- R7: `acc_byte` repeats `is_byte` (1 = byte access, 0 = 32-bit word access) and `acc_load` repeats `is_load` (1 = load, 0 = store).
- R8: `acc_wdata` is `st_data` for a word store, `st_data[7:0]` zero-extended for a byte store, and 0 for a load.
- R9: `flush_req` is 1 exactly for a legal load whose `rd` is 15.
- R10: A cycle with `ld_rsp_valid` high gives `ld_out_valid` high on the next cycle, with `ld_out_data` equal to `ld_rsp_data[7:0]` zero-extended when `ld_rsp_byte` is 1 and to `ld_rsp_data` when it is 0.
- R11: While `rst_n` is low every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| base_val | input | 32 | Base register value |
| base_is_pc | input | 1 | Base register is the program counter |
| off_is_reg | input | 1 | 1 = register offset, 0 = immediate offset |
| off_imm | input | 12 | Immediate offset magnitude |
| off_reg_val | input | 32 | Shifted register offset value |
| off_up | input | 1 | 1 = add offset, 0 = subtract |
| pre_index | input | 1 | 1 = access at effective address, 0 = at base |
| wb_en | input | 1 | Write effective address back to base |
| rn | input | 4 | Base register number |
| rd | input | 4 | Destination/source register number |
| is_load | input | 1 | 1 = load, 0 = store |
| is_byte | input | 1 | 1 = byte, 0 = word |
| st_data | input | 32 | Store data |
| ld_rsp_valid | input | 1 | Load data returned from memory |
| ld_rsp_byte | input | 1 | Returned load was a byte access |
| ld_rsp_data | input | 32 | Raw returned load data |
| out_valid | output | 1 | Result pulse |
| acc_valid | output | 1 | Memory access issued |
| acc_addr | output | 32 | Access address |
| acc_byte | output | 1 | Access width is a byte |
| acc_load | output | 1 | Access is a load |
| acc_wdata | output | 32 | Formatted store data |
| wb_valid | output | 1 | Base register writeback |
| wb_reg | output | 4 | Writeback register number |
| wb_value | output | 32 | Writeback value |
| illegal | output | 1 | Illegal writeback combination |
| flush_req | output | 1 | Pipeline flush request |
| ld_out_valid | output | 1 | Formatted load data valid |
| ld_out_data | output | 32 | Formatted load data |

## Verification
Directed requests pair each index mode with each offset sign. This separates a swapped pre/post select from a wrong offset sign, and the immediate and register sources are tried with magnitudes that differ so a wrong source pick shows. Bases near zero and near the top of the address space force wraparound in both directions. A program counter base combined with post-indexing shows whether the +8 correction reaches both the access and the writeback. The legality check is tried with rn equal to rd with and without writeback, and with a load into register 15 both legal and illegal. A long run of random requests with idle gaps then checks the single-cycle pulse and every field against the reference model.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  localparam int unsigned XLEN_DEF  = 32;
  localparam int unsigned IMM_W_DEF = 12;
  localparam int unsigned REG_W_DEF = 4;
  localparam int unsigned PC_REG_DEF = 15;
  localparam int unsigned PC_ADJ_DEF = 8;

  typedef enum logic {
    WIDTH_WORD = 1'b0,
    WIDTH_BYTE = 1'b1
  } acc_width_e;
endpackage

// File: rtl/ldst_offset_sel.sv
module ldst_offset_sel #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 12
) (
  input  logic            off_is_reg,
  input  logic [IMM_W-1:0] off_imm,
  input  logic [XLEN-1:0] off_reg_val,
  output logic [XLEN-1:0] off_mag
);
  localparam int unsigned PAD_W = (XLEN > IMM_W) ? XLEN - IMM_W : 0;

  logic [XLEN-1:0] imm_ext;

  generate
    if (PAD_W == 0) begin : g_imm_full
      assign imm_ext = off_imm[XLEN-1:0];
    end else begin : g_imm_pad
      assign imm_ext = {{PAD_W{1'b0}}, off_imm};
    end
  endgenerate

  assign off_mag = off_is_reg ? off_reg_val : imm_ext;
endmodule

// File: rtl/ldst_addr_path.sv
module ldst_addr_path #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned PC_ADJ = 8
) (
  input  logic [XLEN-1:0] base_val,
  input  logic            base_is_pc,
  input  logic [XLEN-1:0] off_mag,
  input  logic            off_up,
  input  logic            pre_index,
  output logic [XLEN-1:0] adj_base,
  output logic [XLEN-1:0] eff_addr,
  output logic [XLEN-1:0] acc_addr
);
  localparam logic [XLEN-1:0] PC_ADJ_V = XLEN'(PC_ADJ);

  function automatic logic [XLEN-1:0] correct_base(input logic [XLEN-1:0] b,
                                                    input logic is_pc);
    return is_pc ? b + PC_ADJ_V : b;
  endfunction

  function automatic logic [XLEN-1:0] signed_offset(input logic [XLEN-1:0] mag,
                                                     input logic up);
    return up ? mag : (~mag + XLEN'(1));
  endfunction

  assign adj_base = correct_base(base_val, base_is_pc);
  assign eff_addr = adj_base + signed_offset(off_mag, off_up);
  assign acc_addr = pre_index ? eff_addr : adj_base;
endmodule

// File: rtl/ldst_legality.sv
module ldst_legality #(
  parameter int unsigned REG_W  = 4,
  parameter int unsigned PC_REG = 15
) (
  input  logic             in_valid,
  input  logic             wb_en,
  input  logic             is_load,
  input  logic [REG_W-1:0] rn,
  input  logic [REG_W-1:0] rd,
  output logic             bad_combo,
  output logic             acc_fire,
  output logic             wb_fire,
  output logic             flush_fire
);
  localparam logic [REG_W-1:0] PC_IDX = REG_W'(PC_REG);

  assign bad_combo  = in_valid & wb_en & (rn == rd);
  assign acc_fire   = in_valid & ~bad_combo;
  assign wb_fire    = acc_fire & wb_en;
  assign flush_fire = acc_fire & is_load & (rd == PC_IDX);
endmodule

// File: rtl/ldst_load_fmt.sv
module ldst_load_fmt #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_rsp_valid,
  input  logic            ld_rsp_byte,
  input  logic [XLEN-1:0] ld_rsp_data,
  output logic            ld_out_valid,
  output logic [XLEN-1:0] ld_out_data
);
  function automatic logic [XLEN-1:0] zext8(input logic [XLEN-1:0] d);
    return {{(XLEN-8){1'b0}}, d[7:0]};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_out_valid <= 1'b0;
      ld_out_data  <= '0;
    end else begin
      ld_out_valid <= ld_rsp_valid;
      if (ld_rsp_valid) begin
        ld_out_data <= ld_rsp_byte ? zext8(ld_rsp_data) : ld_rsp_data;
      end
    end
  end
endmodule

// File: rtl/ldst_agu.sv
module ldst_agu #(
  parameter int unsigned XLEN   = ldst_pkg::XLEN_DEF,
  parameter int unsigned IMM_W  = ldst_pkg::IMM_W_DEF,
  parameter int unsigned REG_W  = ldst_pkg::REG_W_DEF,
  parameter int unsigned PC_REG = ldst_pkg::PC_REG_DEF,
  parameter int unsigned PC_ADJ = ldst_pkg::PC_ADJ_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [XLEN-1:0]  base_val,
  input  logic             base_is_pc,
  input  logic             off_is_reg,
  input  logic [IMM_W-1:0] off_imm,
  input  logic [XLEN-1:0]  off_reg_val,
  input  logic             off_up,
  input  logic             pre_index,
  input  logic             wb_en,
  input  logic [REG_W-1:0] rn,
  input  logic [REG_W-1:0] rd,
  input  logic             is_load,
  input  logic             is_byte,
  input  logic [XLEN-1:0]  st_data,
  input  logic             ld_rsp_valid,
  input  logic             ld_rsp_byte,
  input  logic [XLEN-1:0]  ld_rsp_data,
  output logic             out_valid,
  output logic             acc_valid,
  output logic [XLEN-1:0]  acc_addr,
  output logic             acc_byte,
  output logic             acc_load,
  output logic [XLEN-1:0]  acc_wdata,
  output logic             wb_valid,
  output logic [REG_W-1:0] wb_reg,
  output logic [XLEN-1:0]  wb_value,
  output logic             illegal,
  output logic             flush_req,
  output logic             ld_out_valid,
  output logic [XLEN-1:0]  ld_out_data
);
  import ldst_pkg::*;

  logic [XLEN-1:0] off_mag;
  logic [XLEN-1:0] adj_base;
  logic [XLEN-1:0] eff_addr;
  logic [XLEN-1:0] addr_pick;
  logic            bad_combo;
  logic            acc_fire;
  logic            wb_fire;
  logic            flush_fire;
  logic [XLEN-1:0] wdata_fmt;
  acc_width_e      width_sel;

  ldst_offset_sel #(.XLEN(XLEN), .IMM_W(IMM_W)) u_off (
    .off_is_reg (off_is_reg),
    .off_imm    (off_imm),
    .off_reg_val(off_reg_val),
    .off_mag    (off_mag)
  );

  ldst_addr_path #(.XLEN(XLEN), .PC_ADJ(PC_ADJ)) u_addr (
    .base_val  (base_val),
    .base_is_pc(base_is_pc),
    .off_mag   (off_mag),
    .off_up    (off_up),
    .pre_index (pre_index),
    .adj_base  (adj_base),
    .eff_addr  (eff_addr),
    .acc_addr  (addr_pick)
  );

  ldst_legality #(.REG_W(REG_W), .PC_REG(PC_REG)) u_legal (
    .in_valid  (in_valid),
    .wb_en     (wb_en),
    .is_load   (is_load),
    .rn        (rn),
    .rd        (rd),
    .bad_combo (bad_combo),
    .acc_fire  (acc_fire),
    .wb_fire   (wb_fire),
    .flush_fire(flush_fire)
  );

  ldst_load_fmt #(.XLEN(XLEN)) u_ldfmt (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_rsp_valid(ld_rsp_valid),
    .ld_rsp_byte (ld_rsp_byte),
    .ld_rsp_data (ld_rsp_data),
    .ld_out_valid(ld_out_valid),
    .ld_out_data (ld_out_data)
  );

  assign width_sel = is_byte ? WIDTH_BYTE : WIDTH_WORD;

  always_comb begin
    wdata_fmt = '0;
    if (!is_load) begin
      if (width_sel == WIDTH_BYTE) wdata_fmt = {{(XLEN-8){1'b0}}, st_data[7:0]};
      else                         wdata_fmt = st_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      acc_valid <= 1'b0;
      acc_addr  <= '0;
      acc_byte  <= 1'b0;
      acc_load  <= 1'b0;
      acc_wdata <= '0;
      wb_valid  <= 1'b0;
      wb_reg    <= '0;
      wb_value  <= '0;
      illegal   <= 1'b0;
      flush_req <= 1'b0;
    end else begin
      out_valid <= in_valid;
      acc_valid <= acc_fire;
      wb_valid  <= wb_fire;
      illegal   <= bad_combo;
      flush_req <= flush_fire;
      if (in_valid) begin
        acc_addr  <= addr_pick;
        acc_byte  <= (width_sel == WIDTH_BYTE);
        acc_load  <= is_load;
        acc_wdata <= wdata_fmt;
        wb_reg    <= rn;
        wb_value  <= eff_addr;
      end
    end
  end
endmodule

// File: rtl/ldst_agu_chk.sv
module ldst_agu_chk #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned IMM_W  = 12,
  parameter int unsigned REG_W  = 4,
  parameter int unsigned PC_REG = 15,
  parameter int unsigned PC_ADJ = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [XLEN-1:0]  base_val,
  input logic             base_is_pc,
  input logic             pre_index,
  input logic             wb_en,
  input logic [REG_W-1:0] rn,
  input logic [REG_W-1:0] rd,
  input logic             is_load,
  input logic             ld_rsp_valid,
  input logic             ld_rsp_byte,
  input logic             out_valid,
  input logic             acc_valid,
  input logic [XLEN-1:0]  acc_addr,
  input logic             acc_byte,
  input logic             acc_load,
  input logic [XLEN-1:0]  acc_wdata,
  input logic             wb_valid,
  input logic             illegal,
  input logic             flush_req,
  input logic             ld_out_valid,
  input logic [XLEN-1:0]  ld_out_data
);
  localparam logic [REG_W-1:0] PC_IDX = REG_W'(PC_REG);

  p_pulse_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_post_uses_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && wb_en == 1'b0 && !pre_index |=>
      acc_addr == $past(base_val) + ($past(base_is_pc) ? XLEN'(PC_ADJ) : XLEN'(0)));
  p_illegal_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !acc_valid && !wb_valid && !flush_req && out_valid);
  p_illegal_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && wb_en && rn == rd |=> illegal);
  p_byte_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_byte && !acc_load |-> acc_wdata[XLEN-1:8] == '0);
  p_flush_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> acc_valid && acc_load);
  p_flush_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !wb_en && is_load && rd == PC_IDX |=> flush_req);
  p_ld_zext_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_rsp_valid && ld_rsp_byte |=> ld_out_valid && ld_out_data[XLEN-1:8] == '0);
endmodule

bind ldst_agu ldst_agu_chk #(
  .XLEN(XLEN), .IMM_W(IMM_W), .REG_W(REG_W), .PC_REG(PC_REG), .PC_ADJ(PC_ADJ)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base_val(base_val),
  .base_is_pc(base_is_pc), .pre_index(pre_index), .wb_en(wb_en), .rn(rn), .rd(rd),
  .is_load(is_load), .ld_rsp_valid(ld_rsp_valid), .ld_rsp_byte(ld_rsp_byte),
  .out_valid(out_valid), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .acc_byte(acc_byte), .acc_load(acc_load), .acc_wdata(acc_wdata),
  .wb_valid(wb_valid), .illegal(illegal), .flush_req(flush_req),
  .ld_out_valid(ld_out_valid), .ld_out_data(ld_out_data)
);

// File: tb/ldst_agu_tb.sv
module ldst_agu_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, base_is_pc, off_is_reg, off_up, pre_index, wb_en;
  logic        is_load, is_byte, ld_rsp_valid, ld_rsp_byte;
  logic [31:0] base_val, off_reg_val, st_data, ld_rsp_data;
  logic [11:0] off_imm;
  logic [3:0]  rn, rd;
  logic        out_valid, acc_valid, acc_byte, acc_load, wb_valid, illegal, flush_req;
  logic        ld_out_valid;
  logic [31:0] acc_addr, acc_wdata, wb_value, ld_out_data;
  logic [3:0]  wb_reg;

  int n_cmp = 0;
  int n_bad = 0;

  // expected values for the next output cycle
  logic        e_ov, e_av, e_ab, e_al, e_wv, e_il, e_fl, e_lv;
  logic [31:0] e_addr, e_wd, e_wbv, e_ld;
  logic [3:0]  e_wr;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldst_agu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base_val(base_val),
    .base_is_pc(base_is_pc), .off_is_reg(off_is_reg), .off_imm(off_imm),
    .off_reg_val(off_reg_val), .off_up(off_up), .pre_index(pre_index), .wb_en(wb_en),
    .rn(rn), .rd(rd), .is_load(is_load), .is_byte(is_byte), .st_data(st_data),
    .ld_rsp_valid(ld_rsp_valid), .ld_rsp_byte(ld_rsp_byte), .ld_rsp_data(ld_rsp_data),
    .out_valid(out_valid), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_byte(acc_byte), .acc_load(acc_load), .acc_wdata(acc_wdata),
    .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_value(wb_value), .illegal(illegal),
    .flush_req(flush_req), .ld_out_valid(ld_out_valid), .ld_out_data(ld_out_data)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_outputs();
    chk("R1", "out_valid", 32'(out_valid), 32'(e_ov));
    chk("R10", "ld_out_valid", 32'(ld_out_valid), 32'(e_lv));
    if (e_lv) chk("R10", "ld_out_data", ld_out_data, e_ld);
    if (e_ov) begin
      chk("R6", "illegal", 32'(illegal), 32'(e_il));
      chk("R6", "acc_valid", 32'(acc_valid), 32'(e_av));
      chk("R5", "wb_valid", 32'(wb_valid), 32'(e_wv));
      chk("R9", "flush_req", 32'(flush_req), 32'(e_fl));
      if (e_av) begin
        chk("R4", "acc_addr", acc_addr, e_addr);
        chk("R7", "acc_byte", 32'(acc_byte), 32'(e_ab));
        chk("R7", "acc_load", 32'(acc_load), 32'(e_al));
        chk("R8", "acc_wdata", acc_wdata, e_wd);
      end
      if (e_wv) begin
        chk("R5", "wb_reg", 32'(wb_reg), 32'(e_wr));
        chk("R3", "wb_value", wb_value, e_wbv);
      end
    end
  endtask

  // reference model: computes expectation from the inputs now being driven
  task automatic model();
    longint base, mag, ea;
    base = longint'(base_val) + (base_is_pc ? 8 : 0);
    mag  = off_is_reg ? longint'(off_reg_val) : longint'(off_imm);
    ea   = off_up ? base + mag : base - mag;
    ea   = ea & 64'hFFFF_FFFF;
    base = base & 64'hFFFF_FFFF;
    e_ov  = in_valid;
    e_il  = in_valid && wb_en && (rn == rd);
    e_av  = in_valid && !e_il;
    e_wv  = e_av && wb_en;
    e_fl  = e_av && is_load && (rd == 4'd15);
    e_addr = pre_index ? ea[31:0] : base[31:0];
    e_wbv = ea[31:0];
    e_wr  = rn;
    e_ab  = is_byte;
    e_al  = is_load;
    e_wd  = is_load ? 32'd0 : (is_byte ? (st_data & 32'hFF) : st_data);
    e_lv  = ld_rsp_valid;
    e_ld  = ld_rsp_byte ? (ld_rsp_data % 256) : ld_rsp_data;
  endtask

  task automatic idle_inputs();
    in_valid = 0; base_is_pc = 0; off_is_reg = 0; off_up = 1; pre_index = 1;
    wb_en = 0; is_load = 0; is_byte = 0; ld_rsp_valid = 0; ld_rsp_byte = 0;
    base_val = 0; off_reg_val = 0; st_data = 0; ld_rsp_data = 0; off_imm = 0;
    rn = 0; rd = 1;
  endtask

  // one cycle: check what the last drive produced, then drive the next request
  task automatic step();
    @(negedge clk);
    compare_outputs();
    model();
  endtask

  task automatic req(input logic [31:0] b, input logic pc, input logic isr,
                     input logic [11:0] imm, input logic [31:0] rv, input logic up,
                     input logic pre, input logic wb, input logic [3:0] n,
                     input logic [3:0] d, input logic ld, input logic by,
                     input logic [31:0] sd);
    @(negedge clk);
    compare_outputs();
    in_valid = 1; base_val = b; base_is_pc = pc; off_is_reg = isr; off_imm = imm;
    off_reg_val = rv; off_up = up; pre_index = pre; wb_en = wb; rn = n; rd = d;
    is_load = ld; is_byte = by; st_data = sd;
    model();
  endtask

  task automatic gap();
    @(negedge clk);
    compare_outputs();
    idle_inputs();
    model();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle_inputs();
    in_valid = 1; ld_rsp_valid = 1; wb_en = 1; rn = 3; rd = 3; is_load = 1; rd = 15;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset holds every output at zero despite active inputs
    chk("R11", "out_valid", 32'(out_valid), 0);
    chk("R11", "acc_valid", 32'(acc_valid), 0);
    chk("R11", "acc_addr", acc_addr, 0);
    chk("R11", "wb_valid", 32'(wb_valid), 0);
    chk("R11", "illegal", 32'(illegal), 0);
    chk("R11", "flush_req", 32'(flush_req), 0);
    chk("R11", "ld_out_valid", 32'(ld_out_valid), 0);
    idle_inputs();
    model();
    rst_n = 1;
    step();
    // R3/R4: immediate, add, pre-index, writeback
    req(32'h0000_1000, 0, 0, 12'h024, 32'hDEAD_0000, 1, 1, 1, 2, 4, 1, 0, 0);
    // R4: post-index, subtract, register offset
    req(32'h0000_1000, 0, 1, 12'h7FF, 32'h0000_0010, 0, 0, 1, 2, 4, 0, 0, 32'h1234_5678);
    // R2: program counter base with post-index and writeback
    req(32'h0000_0100, 1, 0, 12'h004, 0, 1, 0, 1, 15, 1, 1, 0, 0);
    // R3: wrap upward and downward
    req(32'hFFFF_FFF0, 0, 0, 12'h020, 0, 1, 1, 1, 5, 6, 1, 1, 0);
    req(32'h0000_0008, 0, 1, 0, 32'h0000_0010, 0, 1, 1, 5, 6, 0, 1, 32'hAABB_CCDD);
    gap();
    // R6: writeback with rn == rd is illegal; without writeback it is legal
    req(32'h0000_2000, 0, 0, 12'h008, 0, 1, 1, 1, 7, 7, 1, 0, 0);
    req(32'h0000_2000, 0, 0, 12'h008, 0, 1, 1, 0, 7, 7, 1, 0, 0);
    // R9: legal load into register 15 flushes, illegal one does not, store does not
    req(32'h0000_3000, 0, 0, 12'h010, 0, 1, 1, 0, 2, 15, 1, 0, 0);
    req(32'h0000_3000, 0, 0, 12'h010, 0, 1, 1, 1, 15, 15, 1, 0, 0);
    req(32'h0000_3000, 0, 0, 12'h010, 0, 1, 1, 0, 2, 15, 0, 0, 32'h0102_0304);
    // R8: byte store masks upper bits
    req(32'h0000_4000, 0, 0, 12'h001, 0, 1, 1, 0, 1, 2, 0, 1, 32'hFFFF_FF5A);
    gap();
    gap();
    // R10: load data formatting
    @(negedge clk); compare_outputs();
    idle_inputs(); ld_rsp_valid = 1; ld_rsp_byte = 1; ld_rsp_data = 32'h8899_AABB; model();
    @(negedge clk); compare_outputs();
    ld_rsp_byte = 0; ld_rsp_data = 32'h8899_AABB; model();
    gap();
    // random traffic with gaps
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      compare_outputs();
      in_valid = ($urandom_range(0, 3) != 0);
      base_val = $urandom(); base_is_pc = $urandom_range(0, 1);
      off_is_reg = $urandom_range(0, 1); off_imm = 12'($urandom());
      off_reg_val = $urandom(); off_up = $urandom_range(0, 1);
      pre_index = $urandom_range(0, 1); wb_en = $urandom_range(0, 1);
      rn = 4'($urandom()); rd = 4'($urandom());
      is_load = $urandom_range(0, 1); is_byte = $urandom_range(0, 1);
      st_data = $urandom(); ld_rsp_valid = $urandom_range(0, 1);
      ld_rsp_byte = $urandom_range(0, 1); ld_rsp_data = $urandom();
      model();
    end
    gap();
    gap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule